// File: doc/BRIEF.md
# Vendor Memory-Write Command Loader

This block sits on the host-to-controller command path and reads a stream of command bytes, one byte per accepted cycle. Each command is framed by a 16-bit opcode sent low byte first, a single length byte, and then exactly that many body bytes. When the opcode is the vendor memory-write command, the first four body bytes form a target address, least significant byte first. The remaining body bytes are written one at a time to a byte-wide memory write port, at consecutive addresses starting from that target.

All other opcodes are parsed only far enough to skip their body. Every command ends with a one-cycle status pulse that reports one of four outcomes: completed, rejected, malformed or ignored. A lock input, sampled when the opcode's high byte arrives, turns the memory opcodes (write, read and launch, each selectable by a parameter mask) into rejected commands. A rejected command is consumed in full without touching memory. The block never executes the launch command, and it has no read port. It understands no framing beyond the opcode and length bytes.

Top module: `vendor_cmd_loader`

## Requirements
- R1: A command is the opcode low byte, then the opcode high byte, then a length byte L, then L body bytes. Every command produces exactly one `doneValid` pulse. The pulse comes in the cycle after its last byte is accepted, which is the length byte when L is 0.
- R2: For opcode 0xFC4C (low byte 0x4C, high byte 0xFC) with the lock not applied and L >= 4, body bytes 0..3 give the target address, least significant byte first. Each following body byte produces one `memWrEn` pulse in the cycle after that byte is accepted, with `memData` equal to the byte.
- R3: `doneStatus` encodes 0 = completed, 1 = rejected, 2 = malformed, 3 = ignored. A memory-write command that passes R2 reports 0, including one with L = 4 that writes nothing.
- R4: Payload byte k (k = 0 .. L-5) is written to target address + k, modulo 2^32.
- R5: `lockEn` is sampled in the cycle the opcode high byte is accepted. If it is 1 and the opcode is 0xFC4C, 0xFC4D or 0xFC4E (with the matching bit of BLOCK_MASK set: bit 0 for 0x4C, bit 1 for 0x4D, bit 2 for 0x4E), the command is consumed with no write and reports 1. Changes to `lockEn` later in the same command have no effect.
- R6: The blocklist and the write decode only apply when the high byte is 0xFC. For example, low byte 0x4C with high byte 0x3F is ignored (status 3) and writes nothing.
- R7: A 0xFC4C command with the lock not applied and L < 4 reports 2 (malformed), writes nothing, and still consumes its L body bytes.
- R8: Opcodes 0xFC4D and 0xFC4E with the lock not applied, and every other opcode, are consumed in full with no write and report 3.
- R9: After reset, `memWrEn` and `doneValid` are 0 and the parser expects an opcode low byte.
- R10: Cycles with `inValid` low change no state and produce no write or status pulse.
- R11: L = 0xFF is accepted. A write command of that length produces 251 writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | `inByte` is accepted this cycle |
| inByte | input | 8 | Command stream byte |
| lockEn | input | 1 | Block the listed memory opcodes |
| memWrEn | output | 1 | Memory byte write strobe |
| memAddr | output | 32 | Write address |
| memData | output | 8 | Write data |
| doneValid | output | 1 | One-cycle end-of-command pulse |
| doneStatus | output | 2 | Outcome code, valid with `doneValid` |

## Verification
The hardest situation to reach from the ports is a lock that changes inside a command. A rejection decided at the opcode high byte must hold through a long body, and a permitted write must continue while the lock rises partway through. The stimulus re-randomises `lockEn` on every body byte after the opcode, so both directions of change are exercised. Directed frames cover a target address just below 2^32 so that the write address wraps, and a full 0xFF length. Random idle gaps are placed between bytes to show that a frame's state survives pauses.

// File: rtl/vcl_pkg.sv
package vcl_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 2;
  localparam int OP_COUNT = 3;
  localparam logic [BYTE_W-1:0] VENDOR_HI = 8'hFC;
  localparam logic [BYTE_W-1:0] OP_WRITE = 8'h4C;  // read = +1, launch = +2

  typedef enum logic [1:0] {
    ST_DONE      = 2'd0,
    ST_REJECT    = 2'd1,
    ST_MALFORMED = 2'd2,
    ST_IGNORED   = 2'd3
  } statusT;

  typedef struct packed {
    logic              opLoLoad;
    logic              addrLoad;
    logic [LANE_W-1:0] addrLane;
    logic              dataWrite;
  } strobeT;
endpackage

// File: rtl/vcl_ctrl.sv
module vcl_ctrl
  import vcl_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int ADDR_BYTES = 4,
  parameter logic [OP_COUNT-1:0] BLOCK_MASK = 3'b111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              lockEn,
  input  logic [BYTE_W-1:0] opLo,
  output strobeT            strobe,
  output logic              doneValid,
  output statusT            doneStatus
);
  typedef enum logic [1:0] {P_OPLO, P_OPHI, P_LEN, P_BODY} phaseT;
  typedef enum logic [1:0] {K_WRITE, K_REJECT, K_MALFORM, K_IGNORE} kindT;

  phaseT phase;
  kindT kind, nextKind, lenKind;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] bodyIdx;
  logic [OP_COUNT-1:0] hitVec;
  logic blockHit, isVendor, inAddr;

  // Blocklist: one comparator per guarded opcode, enabled by the mask.
  for (genvar g = 0; g < OP_COUNT; g++) begin : g_block
    assign hitVec[g] = BLOCK_MASK[g] && (opLo == OP_WRITE + BYTE_W'(g));
  end
  assign blockHit = |hitVec;

  function automatic statusT statusOf(input kindT k);
    case (k)
      K_WRITE:  return ST_DONE;
      K_REJECT: return ST_REJECT;
      K_MALFORM: return ST_MALFORMED;
      default:  return ST_IGNORED;
    endcase
  endfunction

  always_comb begin
    isVendor = (inByte == VENDOR_HI);
    if (isVendor && lockEn && blockHit) nextKind = K_REJECT;
    else if (isVendor && opLo == OP_WRITE) nextKind = K_WRITE;
    else nextKind = K_IGNORE;
    lenKind = (kind == K_WRITE && inByte < BYTE_W'(ADDR_BYTES)) ? K_MALFORM : kind;
    inAddr = (bodyIdx < LEN_W'(ADDR_BYTES));
  end

  always_comb begin
    strobe.opLoLoad  = inValid && phase == P_OPLO;
    strobe.addrLoad  = inValid && phase == P_BODY && kind == K_WRITE && inAddr;
    strobe.addrLane  = bodyIdx[LANE_W-1:0];
    strobe.dataWrite = inValid && phase == P_BODY && kind == K_WRITE && !inAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= P_OPLO;
      kind       <= K_IGNORE;
      remain     <= '0;
      bodyIdx    <= '0;
      doneValid  <= 1'b0;
      doneStatus <= ST_DONE;
    end else begin
      doneValid <= 1'b0;
      if (inValid) begin
        case (phase)
          P_OPLO: phase <= P_OPHI;
          P_OPHI: begin
            kind  <= nextKind;  // lock decision frozen here
            phase <= P_LEN;
          end
          P_LEN: begin
            kind    <= lenKind;
            remain  <= inByte;
            bodyIdx <= '0;
            if (inByte == '0) begin
              doneValid  <= 1'b1;
              doneStatus <= statusOf(lenKind);
              phase      <= P_OPLO;
            end else begin
              phase <= P_BODY;
            end
          end
          default: begin
            remain  <= remain - 1'b1;
            bodyIdx <= bodyIdx + 1'b1;
            if (remain == LEN_W'(1)) begin
              doneValid  <= 1'b1;
              doneStatus <= statusOf(kind);
              phase      <= P_OPLO;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/vcl_datapath.sv
module vcl_datapath
  import vcl_pkg::*;
#(
  parameter int ADDR_W = 32,
  localparam int ADDR_BYTES = ADDR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] inByte,
  input  strobeT            strobe,
  output logic [BYTE_W-1:0] opLo,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memData
);
  logic [ADDR_W-1:0] cursor, cursorNext;
  logic [ADDR_BYTES-1:0][BYTE_W-1:0] laneNext;

  // Address arrives least significant byte first; each lane loads its own byte.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
    assign laneNext[g] = (strobe.addrLane == LANE_W'(g)) ? inByte
                                                         : cursor[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    cursorNext = cursor;
    if (strobe.addrLoad) cursorNext = laneNext;
    else if (strobe.dataWrite) cursorNext = cursor + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opLo    <= '0;
      cursor  <= '0;
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      if (strobe.opLoLoad) opLo <= inByte;
      cursor  <= cursorNext;
      memWrEn <= strobe.dataWrite;
      if (strobe.dataWrite) begin
        memAddr <= cursor;
        memData <= inByte;
      end
    end
  end
endmodule

// File: rtl/vendor_cmd_loader.sv
module vendor_cmd_loader
  import vcl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 8,
  parameter logic [OP_COUNT-1:0] BLOCK_MASK = 3'b111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        inByte,
  input  logic              lockEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memData,
  output logic              doneValid,
  output logic [1:0]        doneStatus
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;

  strobeT strobe;
  statusT statusCode;
  logic [BYTE_W-1:0] opLo;

  vcl_ctrl #(
    .LEN_W(LEN_W), .ADDR_BYTES(ADDR_BYTES), .BLOCK_MASK(BLOCK_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .lockEn(lockEn),
    .opLo(opLo), .strobe(strobe), .doneValid(doneValid), .doneStatus(statusCode)
  );

  vcl_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .inByte(inByte), .strobe(strobe), .opLo(opLo),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData)
  );

  assign doneStatus = statusCode;
endmodule

// File: rtl/vcl_checker.sv
module vcl_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              doneValid,
  input logic [1:0]        doneStatus
);
  // R4: back-to-back writes belong to one command and step the address by one
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && $past(memWrEn) |-> memAddr == $past(memAddr) + ADDR_W'(1));
  // R10: no write without a byte accepted in the cycle before
  p_wr_needs_byte_r10: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(inValid));
  // R1: a status pulse only follows an accepted byte
  p_done_needs_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(inValid));
  // R5: the last byte of a rejected command writes nothing
  p_reject_silent_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneStatus == 2'd1 |-> !memWrEn);
  // R7: the last byte of a malformed command writes nothing
  p_malformed_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneStatus == 2'd2 |-> !memWrEn);
  // R8: the last byte of an ignored command writes nothing
  p_ignored_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneStatus == 2'd3 |-> !memWrEn);
endmodule

bind vendor_cmd_loader vcl_checker #(.ADDR_W(ADDR_W)) u_vcl_checker (
  .clk(clk), .rstN(rstN), .inValid(inValid), .memWrEn(memWrEn), .memAddr(memAddr),
  .doneValid(doneValid), .doneStatus(doneStatus)
);

// File: tb/sim_vendor_cmd_loader.sv
module sim_vendor_cmd_loader;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic lockEn = 1'b0;
  logic memWrEn, doneValid;
  logic [31:0] memAddr;
  logic [7:0] memData;
  logic [1:0] doneStatus;

  int nChecks = 0;
  int nFails = 0;
  bit gapsOn = 1'b0;
  bit lockWobble = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  vendor_cmd_loader u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .lockEn(lockEn),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .doneValid(doneValid), .doneStatus(doneStatus)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected outcome: 0 done, 1 rejected, 2 malformed, 3 ignored
  function automatic int expKind(input logic [7:0] lo, input logic [7:0] hi,
                                 input int len, input bit lk);
    if (hi == 8'hFC && lk && (lo == 8'h4C || lo == 8'h4D || lo == 8'h4E)) return 1;
    if (hi == 8'hFC && lo == 8'h4C) return (len < 4) ? 2 : 0;
    return 3;
  endfunction

  // Outputs must stay quiet on idle cycles (R10).
  task automatic idleCheck();
    @(posedge clk);
    @(negedge clk);
    chk(memWrEn == 1'b0, "R10", "idle write", memWrEn, 0);
    chk(doneValid == 1'b0, "R10", "idle status", doneValid, 0);
  endtask

  // Called at a negedge; drives one byte and checks the result one cycle later.
  task automatic put(input logic [7:0] b, input bit ew, input logic [31:0] ea,
                     input bit es, input int st, input string req);
    inValid = 1'b1;
    inByte  = b;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk(memWrEn == ew, req, "write strobe", memWrEn, ew);
    if (ew) begin
      chk(memAddr == ea, "R4", "write address", memAddr, ea);
      chk(memData == b, "R2", "write data", memData, b);
    end
    chk(doneValid == es, "R1", "status pulse", doneValid, es);
    if (es) chk(doneStatus == 2'(st), "R3", "status code", doneStatus, st);
    if (gapsOn) repeat ($urandom_range(0, 2)) idleCheck();
  endtask

  task automatic sendFrame(input logic [7:0] lo, input logic [7:0] hi, input int len,
                           input logic [31:0] addr, input bit lk, input string req);
    int k;
    k = expKind(lo, hi, len, lk);
    put(lo, 1'b0, '0, 1'b0, 0, req);
    lockEn = lk;
    put(hi, 1'b0, '0, 1'b0, 0, req);
    if (lockWobble) lockEn = 1'($urandom);
    put(8'(len), 1'b0, '0, len == 0, k, req);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      bit ew;
      b  = (i < 4) ? addr[8*i +: 8] : 8'($urandom);
      ew = (k == 0) && (i >= 4);
      if (lockWobble) lockEn = 1'($urandom);  // R5: late lock changes ignored
      put(b, ew, addr + 32'(i - 4), i == len - 1, k, req);
    end
    lockEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9: quiet after reset
    chk(memWrEn == 1'b0, "R9", "reset write", memWrEn, 0);
    chk(doneValid == 1'b0, "R9", "reset status", doneValid, 0);
    idleCheck();

    sendFrame(8'h4C, 8'hFC, 16'h10, 32'h0020_0400, 1'b0, "R2");   // 12 payload bytes
    sendFrame(8'h4C, 8'hFC, 4, 32'h1234_5678, 1'b0, "R3");         // address only
    sendFrame(8'h4C, 8'hFC, 3, 32'h0, 1'b0, "R7");                 // short -> malformed
    sendFrame(8'h4C, 8'hFC, 0, 32'h0, 1'b0, "R7");                 // empty -> malformed
    sendFrame(8'h4C, 8'hFC, 12, 32'hFFFF_FFFC, 1'b0, "R4");        // address wrap
    sendFrame(8'h4C, 8'hFC, 255, 32'h0017_A210, 1'b0, "R11");      // maximum length
    sendFrame(8'h4C, 8'hFC, 9, 32'h100, 1'b1, "R5");               // locked write
    sendFrame(8'h4D, 8'hFC, 8, 32'h100, 1'b1, "R5");               // locked read
    sendFrame(8'h4E, 8'hFC, 2, 32'h100, 1'b1, "R5");               // locked launch, short
    sendFrame(8'h4C, 8'hFC, 0, 32'h0, 1'b1, "R5");                 // locked beats malformed
    sendFrame(8'h4D, 8'hFC, 8, 32'h100, 1'b0, "R8");               // read ignored
    sendFrame(8'h4E, 8'hFC, 6, 32'h100, 1'b0, "R8");               // launch ignored
    sendFrame(8'h4F, 8'hFC, 7, 32'h100, 1'b1, "R8");               // unlisted vendor op
    sendFrame(8'h4C, 8'h3F, 9, 32'h200, 1'b1, "R6");               // wrong high byte
    sendFrame(8'h4C, 8'h3F, 0, 32'h0, 1'b0, "R6");
    sendFrame(8'h4C, 8'hFC, 10, 32'h300, 1'b0, "R2");              // follows to check resync

    lockWobble = 1'b1;
    gapsOn = 1'b1;
    sendFrame(8'h4C, 8'hFC, 40, 32'hABCD_0000, 1'b0, "R5");
    sendFrame(8'h4C, 8'hFC, 40, 32'hABCD_0000, 1'b1, "R5");
    for (int n = 0; n < 60; n++) begin
      logic [7:0] lo, hi;
      int pick;
      pick = $urandom_range(0, 5);
      lo = (pick < 3) ? 8'h4C : (pick == 3) ? 8'h4D : (pick == 4) ? 8'h4E : 8'($urandom);
      hi = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'hFC;
      sendFrame(lo, hi, $urandom_range(0, 40), $urandom, 1'($urandom), "R1");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule